// File: doc/BRIEF.md
# Status Register and Write-Protect Arbiter

This block keeps the eight-bit status byte of a serial nonvolatile memory and decides whether any write may proceed. It sits beside the command decoder of the serial front end. The decoder raises a one-cycle pulse for the enable-write, disable-write and status-write commands. For a status write it presents the data byte, and it marks the moment chip select rises, which starts the internal write cycle. The block returns the status byte for a status read. It also answers two questions without delay: may the current array address be written, and may the status register be written.

Protection comes from four sources: the active-low hardware protect pin, the protect-enable bit, the write-enable latch and a two-bit block-protect code. The hardware pin acts only while the protect-enable bit is set. A status write is held pending from the moment its data byte arrives until chip select rises. If the hardware lock takes hold before that point, the pending write is dropped. Once the cycle has begun, the pin can no longer affect it. The protect-enable bit and the block-protect code stand in for nonvolatile cells, so their reset values are parameters.

Top module: `status_guard`

## Requirements
- R1: After reset, status_o[7] equals the parameter WPEN_RST and status_o[3:2] equals BP_RST. The write-enable latch status_o[1] is 0.
- R2: status_o holds protect-enable in bit 7, zeros in bits 6 to 4, the block-protect code in bits 3:2, the write-enable latch in bit 1 and busy_i in bit 0.
- R3: A wren_i pulse sets the write-enable latch in the next cycle, and a wrdi_i pulse clears it. When both arrive in the same cycle, the latch ends up cleared.
- R4: While busy_i is 1, wren_i and wrdi_i have no effect on the write-enable latch.
- R5: A cycle_done_i pulse clears the write-enable latch in the next cycle, whatever the other inputs are.
- R6: arr_wr_ok_o is 1 only when the latch is set and the address is outside the protected range. The range uses addr_i's top two bits T: code 00 protects nothing, 01 protects T=11, 10 protects T=1x, 11 protects every address. The hardware lock does not change this output.
- R7: The hardware lock is active when wp_ni is 0 and protect-enable is 1. sr_wr_ok_o is 1 exactly when the latch is set and the hardware lock is off.
- R8: A committed status write copies data bits 7, 3 and 2 into protect-enable, BP1 and BP0 in the cycle after wrsr_commit_i. Data bits 6 to 4, 1 and 0 are discarded. Without a commit, bits 7 to 2 never change.
- R9: wrsr_stage_i is accepted only when sr_wr_ok_o is 1 and busy_i is 0. A commit with no accepted stage pending leaves the status unchanged.
- R10: A pending status write is cancelled in any cycle where the hardware lock is active before or during the commit cycle. A commit pulse always ends the pending state.
- R11: When protect-enable is 0, wp_ni has no effect on sr_wr_ok_o or on accepting and committing a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Hardware write-protect pin, active low |
| wren_i | input | 1 | Enable-write command pulse |
| wrdi_i | input | 1 | Disable-write command pulse |
| wrsr_stage_i | input | 1 | Status write data byte received |
| wrsr_data_i | input | 8 | Status write data byte |
| wrsr_commit_i | input | 1 | Chip select rose after a status write; internal cycle begins |
| busy_i | input | 1 | Internal write cycle in progress |
| cycle_done_i | input | 1 | Internal write cycle completed |
| addr_i | input | ADDR_W | Array address being queried |
| arr_wr_ok_o | output | 1 | Array address may be written |
| sr_wr_ok_o | output | 1 | Status register may be written |
| status_o | output | 8 | Status byte for a status read |

## Verification
Some events can land on the same clock edge, and each such collision is driven on purpose. A falling protect pin can meet a status commit. Enable and disable pulses can arrive together. A completion pulse can meet an enable request while busy. In each case the expected outcome follows the requirement's stated priority: the cancel wins over the commit, disable wins over enable, and completion clears the latch. Random phases give the pulses and pin changes independent low probabilities so that such overlaps recur many times. Every cycle, the status byte and both permission outputs are compared with a bench model built from the requirements.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_e;

  localparam int unsigned SR_W      = 8;
  localparam int unsigned SR_WPEN   = 7;
  localparam int unsigned SR_BP_HI  = 3;
  localparam int unsigned SR_BP_LO  = 2;
  localparam int unsigned SR_WEL    = 1;
  localparam int unsigned SR_RDY    = 0;

  typedef struct packed {
    logic wpen;
    bp_e  bp;
  } nv_bits_t;
endpackage

// File: rtl/sg_range_dec.sv
module sg_range_dec
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  bp_e               bp_i,
  output logic              prot_o
);
  localparam int unsigned TOP_LSB = ADDR_W - 2;

  logic [1:0] top;

  generate
    if (ADDR_W < 2) begin : g_bad
      initial $error("sg_range_dec: ADDR_W must be at least 2");
      assign top = 2'b00;
    end else begin : g_ok
      assign top = addr_i[ADDR_W-1:TOP_LSB];
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      BP_NONE: prot_o = 1'b0;
      BP_QTR:  prot_o = (top == 2'b11);
      BP_HALF: prot_o = top[1];
      BP_ALL:  prot_o = 1'b1;
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/sg_wel.sv
module sg_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic busy_i,
  input  logic cycle_done_i,
  output logic wel_o
);
  logic wel_q, wel_d;

  always_comb begin
    wel_d = wel_q;
    if (cycle_done_i) begin
      wel_d = 1'b0;
    end else if (!busy_i) begin
      if (wrdi_i)      wel_d = 1'b0;
      else if (wren_i) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wel_q <= 1'b0;
    else         wel_q <= wel_d;
  end

  assign wel_o = wel_q;
endmodule

// File: rtl/sg_sr_stage.sv
module sg_sr_stage
  import sg_pkg::*;
#(
  parameter logic       WPEN_RST = 1'b0,
  parameter logic [1:0] BP_RST   = 2'b00
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stage_i,
  input  logic [SR_W-1:0] data_i,
  input  logic            stage_ok_i,
  input  logic            commit_i,
  input  logic            hw_lock_i,
  output nv_bits_t        nv_o
);
  localparam nv_bits_t NV_RST = '{wpen: WPEN_RST, bp: bp_e'(BP_RST)};

  nv_bits_t nv_q, nv_d, pend_q, pend_d;
  logic     pend_vld_q, pend_vld_d;

  always_comb begin
    nv_d       = nv_q;
    pend_d     = pend_q;
    pend_vld_d = pend_vld_q;
    if (commit_i) begin
      // cycle starts here; lock in this cycle still cancels
      if (pend_vld_q && !hw_lock_i) nv_d = pend_q;
      pend_vld_d = 1'b0;
    end else if (pend_vld_q && hw_lock_i) begin
      pend_vld_d = 1'b0;
    end else if (stage_i && stage_ok_i) begin
      pend_vld_d  = 1'b1;
      pend_d.wpen = data_i[SR_WPEN];
      pend_d.bp   = bp_e'(data_i[SR_BP_HI:SR_BP_LO]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q       <= NV_RST;
      pend_q     <= NV_RST;
      pend_vld_q <= 1'b0;
    end else begin
      nv_q       <= nv_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign nv_o = nv_q;
endmodule

// File: rtl/status_guard.sv
module status_guard
  import sg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 15,
  parameter logic        WPEN_RST = 1'b0,
  parameter logic [1:0]  BP_RST   = 2'b00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_stage_i,
  input  logic [SR_W-1:0]   wrsr_data_i,
  input  logic              wrsr_commit_i,
  input  logic              busy_i,
  input  logic              cycle_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              arr_wr_ok_o,
  output logic              sr_wr_ok_o,
  output logic [SR_W-1:0]   status_o
);
  logic     wel;
  logic     hw_lock;
  logic     prot;
  nv_bits_t nv;

  sg_wel i_wel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .busy_i      (busy_i),
    .cycle_done_i(cycle_done_i),
    .wel_o       (wel)
  );

  // pin is blocked unless the protect-enable bit is set
  assign hw_lock    = ~wp_ni & nv.wpen;
  assign sr_wr_ok_o = wel & ~hw_lock;

  sg_sr_stage #(
    .WPEN_RST(WPEN_RST),
    .BP_RST  (BP_RST)
  ) i_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stage_i   (wrsr_stage_i),
    .data_i    (wrsr_data_i),
    .stage_ok_i(sr_wr_ok_o & ~busy_i),
    .commit_i  (wrsr_commit_i),
    .hw_lock_i (hw_lock),
    .nv_o      (nv)
  );

  sg_range_dec #(
    .ADDR_W(ADDR_W)
  ) i_range (
    .addr_i(addr_i),
    .bp_i  (nv.bp),
    .prot_o(prot)
  );

  assign arr_wr_ok_o = wel & ~prot;

  always_comb begin
    status_o                   = '0;
    status_o[SR_WPEN]          = nv.wpen;
    status_o[SR_BP_HI:SR_BP_LO] = nv.bp;
    status_o[SR_WEL]           = wel;
    status_o[SR_RDY]           = busy_i;
  end
endmodule

// File: rtl/status_guard_chk.sv
module status_guard_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_ni,
  input logic              wren_i,
  input logic              wrdi_i,
  input logic              wrsr_commit_i,
  input logic              busy_i,
  input logic              cycle_done_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              arr_wr_ok_o,
  input logic              sr_wr_ok_o,
  input logic [7:0]        status_o
);
  // R3
  wren_sets_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wren_i && !wrdi_i && !busy_i && !cycle_done_i |=> status_o[1]);

  // R3
  wrdi_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrdi_i && !busy_i |=> !status_o[1]);

  // R4
  busy_holds_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !cycle_done_i |=> $stable(status_o[1]));

  // R5
  done_clears_wel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_done_i |=> !status_o[1]);

  // R2
  unused_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);

  // R6
  full_prot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3:2] == 2'b11 |-> !arr_wr_ok_o);

  // R6
  no_wel_arr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[1] |-> !arr_wr_ok_o && !sr_wr_ok_o);

  // R7
  hw_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni && status_o[7] |-> !sr_wr_ok_o);

  // R8
  nv_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrsr_commit_i |=> $stable(status_o[7:2]));

  // R11
  wpen_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] |-> sr_wr_ok_o == status_o[1]);
endmodule

bind status_guard status_guard_chk #(.ADDR_W(ADDR_W)) i_status_guard_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wp_ni        (wp_ni),
  .wren_i       (wren_i),
  .wrdi_i       (wrdi_i),
  .wrsr_commit_i(wrsr_commit_i),
  .busy_i       (busy_i),
  .cycle_done_i (cycle_done_i),
  .addr_i       (addr_i),
  .arr_wr_ok_o  (arr_wr_ok_o),
  .sr_wr_ok_o   (sr_wr_ok_o),
  .status_o     (status_o)
);

// File: tb/test_status_guard.sv
module test_status_guard;
  localparam int unsigned AW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_n = 1'b1, wren = 1'b0, wrdi = 1'b0, stage = 1'b0;
  logic [7:0]    sdata = '0;
  logic          commit = 1'b0, busy = 1'b0, done = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          arr_ok, sr_ok;
  logic [7:0]    status;

  int checks = 0;
  int errors = 0;

  // bench model
  logic       m_wel, m_wpen, m_pend, m_pwpen;
  logic [1:0] m_bp, m_pbp;

  always #10 clk = ~clk;

  status_guard #(.ADDR_W(AW), .WPEN_RST(1'b1), .BP_RST(2'b01)) i_status_guard (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .wrsr_stage_i(stage), .wrsr_data_i(sdata), .wrsr_commit_i(commit),
    .busy_i(busy), .cycle_done_i(done), .addr_i(addr),
    .arr_wr_ok_o(arr_ok), .sr_wr_ok_o(sr_ok), .status_o(status)
  );

  function automatic logic prot_f(logic [AW-1:0] a, logic [1:0] bp);
    logic [1:0] t = a[AW-1 -: 2];
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return t == 2'b11;
      2'b10:   return t[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic lock_f();
    return !wp_n && m_wpen;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic model_check();
    chk(status, {m_wpen, 3'b000, m_bp, m_wel, busy}, "R2 status byte");
    chk({7'd0, sr_ok}, {7'd0, m_wel & !lock_f()}, "R7 sr_wr_ok");
    chk({7'd0, arr_ok}, {7'd0, m_wel & !prot_f(addr, m_bp)}, "R6 arr_wr_ok");
  endtask

  task automatic model_update();
    logic ok = m_wel && !lock_f() && !busy;
    logic n_wel = m_wel;
    if (done) n_wel = 1'b0;
    else if (!busy) begin
      if (wrdi) n_wel = 1'b0;
      else if (wren) n_wel = 1'b1;
    end
    if (commit) begin
      if (m_pend && !lock_f()) begin
        m_wpen = m_pwpen;
        m_bp   = m_pbp;
      end
      m_pend = 1'b0;
    end else if (m_pend && lock_f()) begin
      m_pend = 1'b0;
    end else if (stage && ok) begin
      m_pend  = 1'b1;
      m_pwpen = sdata[7];
      m_pbp   = sdata[3:2];
    end
    m_wel = n_wel;
  endtask

  task automatic step();
    #1;
    model_check();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic clr();
    wren = 0; wrdi = 0; stage = 0; commit = 0; done = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    m_wel = 0; m_wpen = 1; m_bp = 2'b01; m_pend = 0; m_pwpen = 0; m_pbp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(status, 8'h84, "R1 reset status");
    chk({7'd0, sr_ok}, 8'h00, "R1 reset sr_wr_ok");
    @(negedge clk);

    // R3 enable
    wren = 1; step(); clr();
    #1 chk({7'd0, status[1]}, 8'h01, "R3 wren sets latch");
    // R6 quarter protection
    addr = 15'h7000; #1 chk({7'd0, arr_ok}, 8'h00, "R6 top quarter protected");
    addr = 15'h5000; #1 chk({7'd0, arr_ok}, 8'h01, "R6 below quarter writable");
    // R4 busy blocks wrdi
    busy = 1; wrdi = 1; step(); clr();
    chk(status, 8'h87, "R4 wrdi ignored while busy");
    busy = 0;
    // R8 only bits 7,3,2 taken
    stage = 1; sdata = 8'hF9; step(); clr();
    commit = 1; step(); clr();
    chk(status, 8'h8A, "R8 masked status write");
    addr = 15'h4000; #1 chk({7'd0, arr_ok}, 8'h00, "R6 half protected");
    // R7 / R9 hardware lock refuses stage
    wp_n = 0; #1 chk({7'd0, sr_ok}, 8'h00, "R7 lock blocks status write");
    stage = 1; sdata = 8'h00; step(); clr();
    wp_n = 1; commit = 1; step(); clr();
    chk(status, 8'h8A, "R9 refused stage has no effect");
    // R10 pin falls while pending
    stage = 1; sdata = 8'h0C; step(); clr();
    wp_n = 0; step(); wp_n = 1;
    commit = 1; step(); clr();
    chk(status, 8'h8A, "R10 falling pin cancels pending write");
    // R10 pin low in commit cycle
    stage = 1; sdata = 8'h00; step(); clr();
    wp_n = 0; commit = 1; step(); clr(); wp_n = 1;
    chk(status, 8'h8A, "R10 lock at commit cancels");
    stage = 1; sdata = 8'h00; step(); clr();
    commit = 1; step(); clr();
    chk(status, 8'h02, "R8 clear protect bits");
    // R11 pin ignored with protect-enable clear
    wp_n = 0; #1 chk({7'd0, sr_ok}, 8'h01, "R11 pin ignored");
    stage = 1; sdata = 8'h04; step(); clr();
    commit = 1; step(); clr();
    chk(status, 8'h06, "R11 write accepted with pin low");
    wp_n = 1;
    // R5 completion clears latch, even against wren
    done = 1; wren = 1; step(); clr();
    chk(status, 8'h04, "R5 completion clears latch");
    // R3 both pulses
    wren = 1; step(); clr();
    wren = 1; wrdi = 1; step(); clr();
    chk({7'd0, status[1]}, 8'h00, "R3 disable wins");

    // random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 6000; i++) begin
      wp_n   = ($urandom % 6) != 0;
      wren   = ($urandom % 5) == 0;
      wrdi   = ($urandom % 12) == 0;
      stage  = ($urandom % 4) == 0;
      sdata  = 8'($urandom);
      commit = ($urandom % 5) == 0;
      busy   = ($urandom % 6) == 0;
      done   = ($urandom % 20) == 0;
      addr   = AW'($urandom);
      step();
    end
    clr(); busy = 0;
    step();
    finish_run();
  end
endmodule